// File: doc/BRIEF.md
# Single-Descriptor Memory Copy Engine

This block moves a run of 32-bit words from one place in memory to another. The work is described by a five-word record held in memory. Software loads the byte address of that record into a pointer register and writes the go bit of the command register. The engine then becomes a bus master on a plain 32-bit request/acknowledge port and proceeds in four phases:

- It reads the whole record.
- It decides whether the record may run.
- It copies the payload. Each round reads up to `BURST` words into a local holding buffer and then writes them out.
- It closes the job by storing a result code in the record's second word.

Progress and outcome are shown in a small write-one-to-clear flag register. Only one record is handled per start. A nonzero link word is reported back to software but is not followed.

The record layout, at byte offsets from the pointer, is:

| Offset | Contents |
|---|---|
| +0 | command word: bit 0 means "armed", bits [23:8] hold the payload length in words |
| +4 | result word: must be zero on entry |
| +8 | source byte address |
| +12 | destination byte address |
| +16 | link word |

Top module: `desc_dma`

## Requirements
- R1: After reset the flag register (reg_addr 2) reads 0, the pointer register (reg_addr 1) reads 0 and mem_req is low. The flag register bits are: bit 0 busy, bit 1 record finished, bit 2 list finished, bit 3 fault, bit 4 record skipped.
- R2: A job begins only when bit 0 of a write to reg_addr 0 arrives while idle. Busy then reads 1 from the next cycle until the result word has been written, or until the record is skipped.
- R3: The five record words are read first, in ascending address order, at pointer+0, +4, +8, +12 and +16.
- R4: Exactly `length` words are copied from the source to the destination in ascending order. Destination words past the end are untouched, for every length from 1 to 9 and for memory latencies of 0 to 2 wait cycles.
- R5: A clean job writes 32'h1 to pointer+4 and sets the record-finished flag. It also sets the list-finished flag when the link word is zero.
- R6: When the link word is nonzero, a clean job sets the record-finished flag only.
- R7: A record whose armed bit is clear, or whose result word is nonzero, is not run. No memory write occurs, the record is left unchanged and only the skipped flag is set.
- R8: A record with a source or destination address that is not a multiple of 4, or with a length of zero, copies nothing. Its result word is written with bit 1 set for misalignment and bit 2 set for zero length, and only the fault flag is set.
- R9: Writing a 1 to a flag bit of reg_addr 2 clears that flag.
- R10: While busy, writes to the pointer register and go requests are ignored.
- R11: Once mem_req is raised, mem_req, mem_we, mem_addr and mem_wdata stay unchanged until the cycle in which mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 2 | register index: 0 command, 1 pointer, 2 flags |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | byte address of the access |
| mem_wdata | output | 32 | write data |
| mem_ack | input | 1 | access completes in this cycle |
| mem_rdata | input | 32 | read data, valid with mem_ack |

## Verification
The assertions assume the following about the memory port:
- mem_ack is asserted only while mem_req is high.
- mem_ack lasts one cycle per access.
- Read data is valid in the acknowledge cycle.

The bench's memory model registers its acknowledge and drops it after every completed access, so it never acknowledges a request that has not been made. The model adds a programmable number of wait cycles, which tests the request-holding rule under stalls.

Records are built only in idle periods. Every record keeps its payload inside the modeled 1 KiB memory, so no address wraps.

// File: rtl/desc_dma.sv
module desc_dma #(
  parameter int BURST   = 4,
  parameter int LEN_LSB = 8,
  parameter int LEN_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int BIW = $clog2(BURST);
  localparam int BCW = $clog2(BURST + 1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_RD, S_WR, S_WB} st_t;

  st_t               st;
  logic [31:0]       desc_p, d_ctrl, d_stat, d_src, d_dst, d_next, sp, dp, wb_val;
  logic [2:0]        wi;
  logic [LEN_W-1:0]  rem;
  logic [BCW-1:0]    bn, bi;
  logic [31:0]       buff [BURST];
  logic              f_done, f_chain, f_err, f_skip;

  function automatic logic [BCW-1:0] clip(input logic [LEN_W-1:0] n);
    return (n > LEN_W'(BURST)) ? BCW'(BURST) : n[BCW-1:0];
  endfunction

  wire              busy     = (st != S_IDLE);
  wire              xfer     = mem_req & mem_ack;
  wire [LEN_W-1:0]  len      = d_ctrl[LEN_LSB +: LEN_W];
  wire              mis      = (d_src[1:0] != 2'b00) || (d_dst[1:0] != 2'b00);
  wire              zlen     = (len == '0);
  wire              skip_now = (st == S_CHECK) && (!d_ctrl[0] || d_stat != 32'h0);
  wire              wb_fin   = (st == S_WB) && xfer;
  wire              go       = reg_we && reg_addr == 2'd0 && reg_wdata[0] && !busy;
  wire              clr      = reg_we && reg_addr == 2'd2;
  wire              last_b   = (bi == bn - BCW'(1));

  assign mem_req   = (st == S_FETCH) || (st == S_RD) || (st == S_WR) || (st == S_WB);
  assign mem_we    = (st == S_WR) || (st == S_WB);
  assign mem_addr  = (st == S_FETCH) ? desc_p + {27'b0, wi, 2'b00} :
                     (st == S_RD)    ? sp :
                     (st == S_WR)    ? dp :
                     (st == S_WB)    ? desc_p + 32'd4 : 32'h0;
  assign mem_wdata = (st == S_WR) ? buff[bi[BIW-1:0]] :
                     (st == S_WB) ? wb_val : 32'h0;

  always_comb begin
    case (reg_addr)
      2'd1:    reg_rdata = desc_p;
      2'd2:    reg_rdata = {27'b0, f_skip, f_err, f_chain, f_done, busy};
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_done <= 1'b0; f_chain <= 1'b0; f_err <= 1'b0; f_skip <= 1'b0;
    end else begin
      f_done  <= (wb_fin && wb_val == 32'h1) | (f_done & ~(clr & reg_wdata[1]));
      f_chain <= (wb_fin && wb_val == 32'h1 && d_next == 32'h0) | (f_chain & ~(clr & reg_wdata[2]));
      f_err   <= (wb_fin && wb_val != 32'h1) | (f_err & ~(clr & reg_wdata[3]));
      f_skip  <= skip_now | (f_skip & ~(clr & reg_wdata[4]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; desc_p <= '0; wi <= '0; rem <= '0; bn <= '0; bi <= '0;
      d_ctrl <= '0; d_stat <= '0; d_src <= '0; d_dst <= '0; d_next <= '0;
      sp <= '0; dp <= '0; wb_val <= '0;
      for (int i = 0; i < BURST; i++) buff[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (reg_we && reg_addr == 2'd1) desc_p <= {reg_wdata[31:2], 2'b00};
          if (go) begin st <= S_FETCH; wi <= '0; end
        end
        S_FETCH: if (xfer) begin
          case (wi)
            3'd0:    d_ctrl <= mem_rdata;
            3'd1:    d_stat <= mem_rdata;
            3'd2:    d_src  <= mem_rdata;
            3'd3:    d_dst  <= mem_rdata;
            default: d_next <= mem_rdata;
          endcase
          if (wi == 3'd4) st <= S_CHECK;
          else wi <= wi + 3'd1;
        end
        S_CHECK: begin
          if (skip_now) st <= S_IDLE;
          else if (mis || zlen) begin
            wb_val <= {29'b0, zlen, mis, 1'b0};
            st     <= S_WB;
          end else begin
            wb_val <= 32'h1;
            rem <= len; sp <= d_src; dp <= d_dst;
            bn <= clip(len); bi <= '0;
            st <= S_RD;
          end
        end
        S_RD: if (xfer) begin
          buff[bi[BIW-1:0]] <= mem_rdata;
          sp <= sp + 32'd4;
          if (last_b) begin bi <= '0; st <= S_WR; end
          else bi <= bi + BCW'(1);
        end
        S_WR: if (xfer) begin
          dp <= dp + 32'd4;
          if (last_b) begin
            bi  <= '0;
            rem <= rem - LEN_W'(bn);
            if (rem == LEN_W'(bn)) st <= S_WB;
            else begin bn <= clip(rem - LEN_W'(bn)); st <= S_RD; end
          end else bi <= bi + BCW'(1);
        end
        S_WB: if (xfer) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [LEN_W-1:0] wr_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) wr_cnt <= '0;
    else if (go) wr_cnt <= '0;
    else if (st == S_WR && xfer) wr_cnt <= wr_cnt + LEN_W'(1);
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10
  ptr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && reg_addr == 2'd1 |=> $stable(desc_p));

  // R4
  word_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fin && wb_val == 32'h1 |-> wr_cnt == len);

  // R7
  skip_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_skip) |-> wr_cnt == '0);

  // R8
  fault_nocopy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_err) |-> wr_cnt == '0);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(xfer && mem_we) || $past(st == S_CHECK));
endmodule

// File: tb/desc_dma_tb.sv
`timescale 1ns/1ps
module desc_dma_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'h0, reg_rdata;
  logic mem_req, mem_we, ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [0:255];
  int lat = 0, gcnt = 0;
  int nchk = 0, nerr = 0;
  bit done_flag = 0;
  logic [31:0] fa [0:4];
  int fi = 0;
  int hold_bad = 0;
  logic pr = 1'b0;
  logic [31:0] pa = 32'h0;

  always #2.5 clk = ~clk;

  desc_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(ack), .mem_rdata(mem_rdata));

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (!rst_n) begin ack <= 1'b0; gcnt <= 0; end
    else begin
      if (ack && mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      if (ack) begin ack <= 1'b0; gcnt <= 0; end
      else if (mem_req) begin
        if (gcnt >= lat) ack <= 1'b1; else gcnt <= gcnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pr && (!mem_req || mem_addr != pa)) hold_bad++;
      pr = mem_req && !ack;
      pa = mem_addr;
      if (mem_req && ack && !mem_we && fi < 5) begin fa[fi] = mem_addr; fi++; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic put_desc(input int w, input logic [31:0] c, s, src, dst, nx);
    mem[w] = c; mem[w+1] = s; mem[w+2] = src; mem[w+3] = dst; mem[w+4] = nx;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd2, d);
      if (!d[0]) return;
    end
    chk(0, "R2 job never finished", 32'h1, 32'h0);
  endtask

  task automatic run(input logic [31:0] ptr);
    logic [31:0] d;
    wr(2'd2, 32'h1E);
    wr(2'd1, ptr);
    fi = 0;
    wr(2'd0, 32'h1);
    rd(2'd2, d);
    chk(d[0] == 1'b1, "R2 busy after go", d, 32'h1);
    wait_idle();
  endtask

  task automatic fill(input logic [31:0] base);
    for (int k = 0; k < 256; k++) mem[k] = base + k;
  endtask

  function automatic int count_bad(input int dw, input int sw, input int n);
    int b = 0;
    for (int k = 0; k < n; k++) if (mem[dw+k] != mem[sw+k]) b++;
    return b;
  endfunction

  initial begin
    logic [31:0] d;
    int sw, dw, bad;
    for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd2, d); chk(d == 32'h0, "R1 flags after reset", d, 32'h0);
    rd(2'd1, d); chk(d == 32'h0, "R1 pointer after reset", d, 32'h0);
    chk(mem_req == 1'b0, "R1 mem_req after reset", {31'b0, mem_req}, 32'h0);

    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int n = 1; n <= 9; n++) begin
        fill(32'hA000_0000 + (l << 16) + (n << 8));
        sw = 64 + (n % 3); dw = 128 + l;
        put_desc(0, 32'h1 | (n << 8), 32'h0, sw * 4, dw * 4, 32'h0);
        run(32'h0);
        bad = count_bad(dw, sw, n);
        chk(bad == 0, $sformatf("R4 copy len=%0d lat=%0d", n, l), bad, 0);
        chk(mem[dw+n] == 32'hA000_0000 + (l << 16) + (n << 8) + dw + n, "R4 word past end",
            mem[dw+n], 32'hA000_0000 + (l << 16) + (n << 8) + dw + n);
        chk(mem[1] == 32'h1, "R5 result word", mem[1], 32'h1);
        rd(2'd2, d); chk(d == 32'h6, "R5 flags clean", d, 32'h6);
        if (n == 5 && l == 1) begin
          bad = 0;
          for (int i = 0; i < 5; i++) if (fa[i] != 32'(4 * i)) bad++;
          chk(bad == 0 && fi == 5, "R3 record fetch order", bad, 0);
        end
        wr(2'd2, 32'h6);
        rd(2'd2, d); chk(d == 32'h0, "R9 clear flags", d, 32'h0);
      end
    end

    lat = 1;
    fill(32'hB000_0000);
    put_desc(8, 32'h1 | (3 << 8), 32'h0, 64 * 4, 128 * 4, 32'h40);
    run(32'd32);
    rd(2'd2, d); chk(d == 32'h2, "R6 link nonzero", d, 32'h2);
    chk(count_bad(128, 64, 3) == 0, "R6 copy", 0, 0);

    fill(32'hC000_0000);
    put_desc(8, 32'h0 | (3 << 8), 32'h0, 64 * 4, 128 * 4, 32'h0);
    run(32'd32);
    rd(2'd2, d); chk(d == 32'h10, "R7 unarmed skipped", d, 32'h10);
    chk(mem[128] == 32'hC000_0000 + 128, "R7 dst untouched", mem[128], 32'hC000_0000 + 128);
    chk(mem[9] == 32'h0, "R7 record unchanged", mem[9], 32'h0);

    put_desc(8, 32'h1 | (3 << 8), 32'h55, 64 * 4, 128 * 4, 32'h0);
    run(32'd32);
    rd(2'd2, d); chk(d == 32'h10, "R7 dirty result skipped", d, 32'h10);
    chk(mem[9] == 32'h55, "R7 result kept", mem[9], 32'h55);
    chk(mem[128] == 32'hC000_0000 + 128, "R7 dst untouched 2", mem[128], 32'hC000_0000 + 128);

    put_desc(8, 32'h1 | (3 << 8), 32'h0, 64 * 4 + 1, 128 * 4, 32'h0);
    run(32'd32);
    rd(2'd2, d); chk(d == 32'h8, "R8 misaligned flags", d, 32'h8);
    chk(mem[9] == 32'h2, "R8 misaligned code", mem[9], 32'h2);
    chk(mem[128] == 32'hC000_0000 + 128, "R8 dst untouched", mem[128], 32'hC000_0000 + 128);

    put_desc(8, 32'h1, 32'h0, 64 * 4, 128 * 4, 32'h0);
    run(32'd32);
    chk(mem[9] == 32'h4, "R8 zero length code", mem[9], 32'h4);

    put_desc(8, 32'h1, 32'h0, 64 * 4, 128 * 4 + 2, 32'h0);
    run(32'd32);
    chk(mem[9] == 32'h6, "R8 both faults code", mem[9], 32'h6);

    lat = 2;
    fill(32'hD000_0000);
    put_desc(0, 32'h1 | (9 << 8), 32'h0, 64 * 4, 128 * 4, 32'h0);
    put_desc(16, 32'h1 | (2 << 8), 32'h0, 80 * 4, 200 * 4, 32'h0);
    wr(2'd2, 32'h1E);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'd64);
    wr(2'd0, 32'h1);
    rd(2'd1, d); chk(d == 32'h0, "R10 pointer locked", d, 32'h0);
    wait_idle();
    chk(mem[17] == 32'h0, "R10 second record not run", mem[17], 32'h0);
    chk(mem[200] == 32'hD000_0000 + 200, "R10 second dst untouched", mem[200], 32'hD000_0000 + 200);
    chk(count_bad(128, 64, 9) == 0, "R10 first job copied", 0, 0);
    rd(2'd2, d); chk(d == 32'h6, "R10 flags", d, 32'h6);

    chk(hold_bad == 0, "R11 request held until ack", hold_bad, 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule